// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches the command pins of a four-bank SDRAM bus, one command per clock edge, and reports any command that breaks a bank-state or spacing rule. It decodes each edge's command from the select and strobe pins, tracks per bank whether a row is open, and counts the cycles since the last activate, the last close, and the last write. It also tracks auto-precharge bursts and the column burst currently on the bus. Every spacing is a parameter given in clock cycles. The defaults suit a 100 MHz part: activate-to-column 2, close-to-activate 2, activate-to-close 5, activate-to-activate on one bank 7, activate-to-activate on any bank 2, write recovery 2, mode-set recovery 2, and burst length 4.

The block is a pure monitor. It drives nothing onto the memory bus. The device state it tracks always follows each command as issued, even when that command is flagged. A flagged command raises `viol` for exactly one cycle, together with a 4-bit code that names the broken rule. When several rules break on one command, the lowest code wins.

Top module: `sdr_cmd_checker`

## Requirements
- R1: After reset `viol` is 0 and `viol_code` is 0. A command sampled at clock edge n is reported by `viol`/`viol_code` after edge n, and the report lasts one cycle only. NOP (cs_n=0, ras_n=cas_n=we_n=1) and deselect (cs_n=1) never raise a report. A deselect changes no bank state, whatever the other pins show.
- R2: Decode (cs_n=0; ras_n,cas_n,we_n): 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop. Any command other than NOP or deselect that comes fewer than T_MRD cycles after a mode set gives code 1.
- R3: A mode set or a refresh while any bank is open gives code 2.
- R4: An activate to an open bank gives code 3. A read or write to a closed bank gives code 4. The bank is selected by ba (0 to 3).
- R5: A read or write fewer than T_RCD cycles after the same bank's activate gives code 6.
- R6: A precharge of an open bank fewer than T_RAS cycles after its activate gives code 10. An activate fewer than T_RC cycles after the same bank's previous activate gives code 7.
- R7: An activate fewer than T_RP cycles after the bank closed gives code 8. A precharge with a10=1 closes every bank and ignores ba.
- R8: An activate fewer than T_RRD cycles after any activate gives code 9.
- R9: A write at edge w has its last data at w+BL-1. A precharge of that bank at w+k, with BL-1 < k < BL-1+T_WR, gives code 11. A precharge with k <= BL-1 is a legal burst interrupt.
- R10: A read or write with a10=1 requests auto-precharge. The bank closes by itself at edge n+BL (read) or n+BL-1+T_WR (write). Before that, a read or write to the bank gives code 5. An activate before the close plus T_RP gives code 8 (or code 3 while still open).
- R11: A single-bank precharge (a10=0) to a bank other than the one whose column burst is still running gives code 12.
- R12: When several rules break at once, the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge request on read/write; all-banks on precharge |
| viol | output | 1 | One-cycle pulse for a flagged command |
| viol_code | output | 4 | Code of the broken rule, 0 when none |

## Verification
The bench targets off-by-one spacing errors. Each rule is hit one cycle short of its limit and then exactly at the limit. A counter that started one edge late or compared with <= would flag the legal case or miss the short one.

Write recovery is probed at three points: inside the burst (a legal interrupt), one cycle after the last data (flagged), and after recovery (legal). A design that measured from the write command instead of from the last data gets one of these wrong.

Auto-precharge is checked by reactivating the bank one cycle early and exactly on time. A design that closed the bank at the wrong edge misreports one of the two.

The remaining probes catch decode and priority slips:
- An all-bank precharge with a nonzero ba must close bank 0.
- A deselect must not open a bank.
- A double activate must report the open-bank code rather than the row-cycle code.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

  typedef enum logic [3:0] {
    C_DESEL, C_NOP, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_PRE, C_BST
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_MRD       = 4'd1,
    V_NOT_IDLE  = 4'd2,
    V_ACT_OPEN  = 4'd3,
    V_RW_CLOSED = 4'd4,
    V_AP_BUSY   = 4'd5,
    V_RCD       = 4'd6,
    V_RC        = 4'd7,
    V_RP        = 4'd8,
    V_RRD       = 4'd9,
    V_RAS       = 4'd10,
    V_WR        = 4'd11,
    V_XBANK     = 4'd12
  } viol_e;

  typedef struct packed {
    logic act_open;
    logic rw_closed;
    logic ap_busy;
    logic rcd;
    logic rc;
    logic rp;
    logic ras;
    logic wr;
  } bank_err_t;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_chk_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RAS = 5,
  parameter int T_RC  = 7,
  parameter int T_WR  = 2,
  parameter int BL    = 4,
  parameter int CW    = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_e      cmd,
  input  logic      hit,
  input  logic      pre_hit,
  input  logic      a10,
  output logic      open_o,
  output bank_err_t err
);
  localparam logic [CW-1:0] SAT   = '1;
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP);
  localparam logic [CW-1:0] K_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] K_RC  = CW'(T_RC);
  localparam logic [CW-1:0] K_BL1 = CW'(BL - 1);
  localparam logic [CW-1:0] K_WRE = CW'(BL - 1 + T_WR);
  localparam logic [CW-1:0] K_APR = CW'(BL);

  logic          open_q, ap_q;
  logic [CW-1:0] s_act, s_pre, s_wr, ap_cnt;
  logic          is_act, is_rw, is_wr, is_pre, ap_fire, closing;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  always_comb begin
    is_act  = hit && (cmd == C_ACT);
    is_wr   = hit && (cmd == C_WR);
    is_rw   = hit && ((cmd == C_RD) || (cmd == C_WR));
    is_pre  = pre_hit && (cmd == C_PRE);
    ap_fire = ap_q && (ap_cnt == CW'(1));
    closing = (is_pre && open_q) || ap_fire;

    err.act_open  = is_act && open_q;
    err.rw_closed = is_rw && !open_q;
    err.ap_busy   = is_rw && ap_q;
    err.rcd       = is_rw && (s_act < K_RCD);
    err.rc        = is_act && (s_act < K_RC);
    err.rp        = is_act && !open_q && (s_pre < K_RP);
    err.ras       = is_pre && open_q && (s_act < K_RAS);
    err.wr        = is_pre && open_q && (s_wr > K_BL1) && (s_wr < K_WRE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      s_act  <= SAT;
      s_pre  <= SAT;
      s_wr   <= SAT;
      ap_cnt <= '0;
    end else begin
      s_act <= is_act ? CW'(1) : sat_inc(s_act);
      s_wr  <= is_wr  ? CW'(1) : sat_inc(s_wr);
      s_pre <= (closing && !is_act) ? CW'(1) : sat_inc(s_pre);
      if (is_act) begin
        open_q <= 1'b1;
        ap_q   <= 1'b0;
      end else if (closing) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
      end else if (is_rw && a10) begin
        ap_q <= 1'b1;
      end
      if (is_rw && a10)              ap_cnt <= is_wr ? K_WRE : K_APR;
      else if (ap_q && ap_cnt != '0) ap_cnt <= ap_cnt - 1'b1;
    end
  end

  assign open_o = open_q;

  // R7: a precharge that hits an open bank leaves it closed
  a_r7_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && open_q) |=> !open_q);

  // R10: the auto-precharge point closes the bank unless reactivated there
  a_r10_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q && ap_cnt == CW'(1) && !is_act) |=> !open_q);

endmodule

// File: rtl/sdr_cmd_checker.sv
module sdr_cmd_checker
  import sdr_chk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RAS = 5,
  parameter int T_RC  = 7,
  parameter int T_RRD = 2,
  parameter int T_WR  = 2,
  parameter int T_MRD = 2,
  parameter int BL    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [$clog2(NB)-1:0] ba,
  input  logic                  a10,
  output logic                  viol,
  output logic [3:0]            viol_code
);
  localparam int BAW  = $clog2(NB);
  localparam int MAXT = T_RCD + T_RP + T_RAS + T_RC + T_RRD + T_WR + T_MRD + BL;
  localparam int CW   = $clog2(MAXT + 2);
  localparam logic [CW-1:0] SAT   = '1;
  localparam logic [CW-1:0] K_MRD = CW'(T_MRD);
  localparam logic [CW-1:0] K_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] K_BL1 = CW'(BL - 1);

  cmd_e          cmd;
  logic [NB-1:0] open_vec, hit, pre_hit;
  bank_err_t     berr [NB];
  bank_err_t     be;
  logic [CW-1:0] s_mrs, s_anyact, brem;
  logic [BAW-1:0] lbank;
  logic          is_real, any_open, e_mrd, e_idle, e_rrd, e_xbank;
  viol_e         win;

  sdr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign hit[g]     = (ba == BAW'(g));
    assign pre_hit[g] = a10 || (ba == BAW'(g));
    sdr_bank_track #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_WR(T_WR), .BL(BL), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(hit[g]),
      .pre_hit(pre_hit[g]), .a10(a10), .open_o(open_vec[g]), .err(berr[g])
    );
  end

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  always_comb begin
    be = '0;
    for (int i = 0; i < NB; i++) be = bank_err_t'(be | berr[i]);
    is_real  = (cmd != C_DESEL) && (cmd != C_NOP);
    any_open = |open_vec;
    e_mrd    = is_real && (s_mrs < K_MRD);
    e_idle   = ((cmd == C_MRS) || (cmd == C_REF)) && any_open;
    e_rrd    = (cmd == C_ACT) && (s_anyact < K_RRD);
    e_xbank  = (cmd == C_PRE) && !a10 && (brem != '0) && (ba != lbank);

    if      (e_mrd)        win = V_MRD;
    else if (e_idle)       win = V_NOT_IDLE;
    else if (be.act_open)  win = V_ACT_OPEN;
    else if (be.rw_closed) win = V_RW_CLOSED;
    else if (be.ap_busy)   win = V_AP_BUSY;
    else if (be.rcd)       win = V_RCD;
    else if (be.rc)        win = V_RC;
    else if (be.rp)        win = V_RP;
    else if (e_rrd)        win = V_RRD;
    else if (be.ras)       win = V_RAS;
    else if (be.wr)        win = V_WR;
    else if (e_xbank)      win = V_XBANK;
    else                   win = V_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_mrs     <= SAT;
      s_anyact  <= SAT;
      brem      <= '0;
      lbank     <= '0;
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else begin
      s_mrs    <= (cmd == C_MRS) ? CW'(1) : sat_inc(s_mrs);
      s_anyact <= (cmd == C_ACT) ? CW'(1) : sat_inc(s_anyact);
      if ((cmd == C_RD) || (cmd == C_WR)) begin
        brem  <= K_BL1;
        lbank <= ba;
      end else if ((cmd == C_BST) || ((cmd == C_PRE) && (a10 || ba == lbank))) begin
        brem <= '0;
      end else if (brem != '0) begin
        brem <= brem - 1'b1;
      end
      viol      <= (win != V_NONE);
      viol_code <= win;
    end
  end

  // R1: NOP and deselect never produce a report
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_NOP) || (cmd == C_DESEL)) |=> !viol);

  // R3: mode set or refresh with a bank open is always reported
  a_r3_busy_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (((cmd == C_MRS) || (cmd == C_REF)) && any_open) |=> viol);

  // R4, R12: activating an open bank reports that code or a higher-priority one
  a_r4_act_open: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_ACT) && open_vec[ba]) |=> (viol && viol_code <= 4'd3));

  if (T_MRD > 1) begin : g_mrd_chk
    // R2: a real command right after a mode set is reported
    a_r2_mrd_next: assert property (@(posedge clk) disable iff (!rst_n)
      (is_real && $past(cmd) == C_MRS) |=> viol);
  end

endmodule

// File: tb/sim_sdr_cmd_checker.sv
module sim_sdr_cmd_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       viol;
  logic [3:0] viol_code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdr_cmd_checker u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .viol(viol), .viol_code(viol_code)
  );

  task automatic issue(input logic c, input logic r, input logic ca,
                       input logic w, input logic [1:0] b, input logic a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
  endtask

  task automatic act(input logic [1:0] b);                issue(0, 0, 1, 1, b, 0);   endtask
  task automatic rd(input logic [1:0] b, input logic ap); issue(0, 1, 0, 1, b, ap);  endtask
  task automatic wr(input logic [1:0] b, input logic ap); issue(0, 1, 0, 0, b, ap);  endtask
  task automatic pre(input logic [1:0] b);                issue(0, 0, 1, 0, b, 0);   endtask
  task automatic preall();                                issue(0, 0, 1, 0, 2'b11, 1); endtask
  task automatic mrs();                                   issue(0, 0, 0, 0, 0, 0);   endtask
  task automatic refr();                                  issue(0, 0, 0, 1, 0, 0);   endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic cleanup(); idle(8); preall(); idle(8); endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    checks++;
    if (viol !== (exp != 4'd0) || viol_code !== exp) begin
      errors++;
      $display("FAIL %s viol=%0b code=%0d expected viol=%0b code=%0d",
               tag, viol, viol_code, (exp != 4'd0), exp);
    end
  endtask

  task automatic t_legal();
    act(0);  chk(0, "R1 legal activate");
    idle(1); rd(0, 0); chk(0, "R5 read at tRCD");
    idle(2); pre(0);   chk(0, "R6 precharge at tRAS");
    idle(1); act(0);   chk(0, "R7 activate at tRP and tRC");
    cleanup();
  endtask

  task automatic t_deselect();
    issue(1, 0, 1, 1, 2'd0, 0); chk(0, "R1 deselect quiet");
    rd(0, 0); chk(4, "R1 deselect left bank closed");
    cleanup();
  endtask

  task automatic t_mrd();
    mrs();   chk(0, "R2 mode set idle");
    act(1);  chk(1, "R2 command one cycle after mode set");
    cleanup();
    mrs(); idle(1); act(1); chk(0, "R2 command at mode-set recovery");
    cleanup();
  endtask

  task automatic t_notidle();
    refr(); chk(0, "R3 refresh all closed");
    act(2); idle(7); refr(); chk(2, "R3 refresh with open bank");
    cleanup();
  endtask

  task automatic t_state();
    act(3); idle(6); act(3); chk(3, "R4 activate open bank");
    cleanup();
    rd(2, 0); chk(4, "R4 read closed bank");
    cleanup();
  endtask

  task automatic t_rcd();
    act(0); rd(0, 0); chk(6, "R5 read before tRCD");
    cleanup();
  endtask

  task automatic t_ras_rc();
    act(1); idle(3); pre(1); chk(10, "R6 precharge before tRAS");
    idle(1); act(1); chk(7, "R6 activate before tRC");
    cleanup();
  endtask

  task automatic t_rp();
    act(0); idle(1); act(2); chk(0, "R8 second bank at tRRD");
    idle(4); preall(); chk(0, "R7 precharge all");
    act(0); chk(8, "R7 activate before tRP after all-bank close");
    cleanup();
  endtask

  task automatic t_rrd();
    act(0); act(1); chk(9, "R8 activate before tRRD");
    cleanup();
  endtask

  task automatic t_wr();
    act(0); idle(1); wr(0, 0); chk(0, "R9 write");
    idle(3); pre(0); chk(11, "R9 precharge inside write recovery");
    cleanup();
    act(0); idle(1); wr(0, 0); idle(2); pre(0); chk(0, "R9 precharge interrupting write burst");
    cleanup();
    act(0); idle(1); wr(0, 0); idle(4); pre(0); chk(0, "R9 precharge after recovery");
    cleanup();
  endtask

  task automatic t_ap();
    act(1); idle(1); rd(1, 1); rd(1, 0); chk(5, "R10 read during auto-precharge burst");
    cleanup();
    act(1); idle(1); rd(1, 1); idle(4); act(1); chk(8, "R10 reactivate one cycle early");
    cleanup();
    act(1); idle(1); rd(1, 1); idle(5); act(1); chk(0, "R10 reactivate on time");
    cleanup();
  endtask

  task automatic t_xbank();
    act(0); idle(1); act(1); idle(4); rd(0, 0);
    pre(1); chk(12, "R11 precharge other bank mid-burst");
    idle(4); rd(0, 0); pre(0); chk(0, "R11 precharge same bank mid-burst");
    cleanup();
  endtask

  task automatic t_prio();
    act(2); act(2); chk(3, "R12 open-bank beats tRC and tRRD");
    idle(1); chk(0, "R1 report lasts one cycle");
    cleanup();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk(0, "R1 reset state");
    t_legal();
    t_deselect();
    t_mrd();
    t_notidle();
    t_state();
    t_rcd();
    t_ras_rc();
    t_rp();
    t_rrd();
    t_wr();
    t_ap();
    t_xbank();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule